// File: doc/BRIEF.md
# Display Sink Discovery Controller

This block sits in a display transmitter and decides what kind of sink is attached. It conditions the hot-plug detect line from the connector, keeps the +5 V cable supply enabled, and, once the sink reports its capability data as readable, fetches the 128-byte base capability block and the first 128-byte extension block. The bytes arrive one at a time through a byte-read request/response port. The port is served by a separate I2C master that runs the 100 kHz display data channel.

Each block is checked with a modulo-256 checksum. A bad block is fetched again a bounded number of times before the block gives up and reports an error. The block then walks the data-block collection of the extension and looks for a vendor-specific entry that carries the HDMI identifier. With that entry the sink is reported as HDMI; without it the sink is reported as DVI. Until a fetch has completed without error, the block tells the video pipeline to keep to the 640x480 progressive default mode.

A low pulse on hot-plug detect means the sink's capability data has changed. The controller drops what it has learned and fetches the data again once the line returns high. If the line drops while a fetch is running, the fetch is abandoned cleanly.

Top module: `sink_discovery_ctrl`

## Requirements
- R1: No read request is issued while the conditioned hot-plug level is low. A request can start only after the synchronized `hpd_in` has been seen high.
- R2: `hpd_in` low for at least `HPD_LOW_MIN` consecutive synchronized cycles is a change pulse: `caps_valid` and `caps_fail` clear and `safe_mode` is 1. A shorter low is ignored: the result is kept and no read is issued.
- R3: `pwr5v_en` is 1 from the first cycles after reset release on, and it is 1 whenever `ddc_rd_req` is 1.
- R4: Bytes are requested one at a time. `ddc_rd_req` stays high until a `ddc_rd_ack` cycle. The base block uses addresses 0..127 in ascending order and the extension uses addresses 128..255. A re-fetch restarts at the first address of the same block.
- R5: If base byte 126 (the extension count) is 0, no address of 128 or above is read and the sink is reported as DVI.
- R6: A block whose 128 bytes do not sum to 0 mod 256 is fetched again, for up to `MAX_RETRY` extra attempts. If every attempt fails, `caps_fail` becomes 1, `caps_valid` stays 0 and `safe_mode` stays 1.
- R7: `sink_hdmi` is 1 only with `caps_valid`. It is 1 only if extension byte 0 equals 0x02 and the data-block collection holds an entry with tag 3 (header bits 7:5), length of at least 3 (header bits 4:0), and next three bytes 0x03, 0x0C, 0x00.
- R8: The collection starts at extension offset 4 and ends before the offset in extension byte 2. Entries are found only by chaining header lengths, so an entry at or beyond the end, or a wrong tag, does not count.
- R9: A drop of the conditioned hot-plug level during a fetch withdraws `ddc_rd_req` on the next cycle. The next fetch starts again at address 0.
- R10: `safe_mode` is 1 exactly when `caps_valid` is 0. Each completed fetch raises `caps_valid` or `caps_fail` once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hpd_in | input | 1 | Raw hot-plug detect from the connector |
| ddc_rd_req | output | 1 | Byte read request to the I2C master |
| ddc_rd_addr | output | 8 | Byte offset within the 256-byte capability space |
| ddc_rd_ack | input | 1 | One-cycle pulse: read data valid |
| ddc_rd_data | input | 8 | Byte returned with the acknowledge |
| pwr5v_en | output | 1 | Enable for the +5 V cable supply |
| caps_valid | output | 1 | Sink capabilities fetched and checked |
| caps_fail | output | 1 | Fetch failed after all retries |
| sink_hdmi | output | 1 | 1 means HDMI sink, 0 means DVI (with caps_valid) |
| safe_mode | output | 1 | Keep to the 640x480 progressive default mode |

## Verification
A wrong state in the sequencer shows at the address port on the next request: an address that is not ascending, a read of the extension after an extension count of zero, or a restart that does not return to a block boundary. Each of these is visible within one acknowledge. A wrong vendor-block walk or checksum accumulator shows only at the end of a block, as a flipped `sink_hdmi` or a `caps_fail` where a valid result was due, so the bench compares every completed result against a queue of expected outcomes. A wrong hot-plug filter shows within a few tens of cycles of a pulse, either as a result kept after a long low or as one dropped after a glitch.

// File: rtl/sinkdisc_pkg.sv
package sinkdisc_pkg;
  localparam int            BLK_BYTES     = 128;
  localparam logic [6:0]    EXT_CNT_OFF   = 7'd126;
  localparam logic [6:0]    LAST_OFF      = 7'd127;
  localparam logic [7:0]    EXT_TAG_CEA   = 8'h02;
  localparam logic [2:0]    DB_TAG_VENDOR = 3'd3;
  localparam logic [7:0]    COLL_START    = 8'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_CHECK,
    ST_DONE,
    ST_FAIL
  } fetch_st_t;
endpackage

// File: rtl/sd_hpd_filter.sv
module sd_hpd_filter #(
  parameter int LOW_MIN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hpd_raw,
  output logic hpd_ok
);
  localparam int CW = $clog2(LOW_MIN + 1);

  logic          s1_q, s2_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= hpd_raw;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (s2_q) begin
      cnt_d = '0;
      lvl_d = 1'b1;
    end else if (cnt_q == CW'(LOW_MIN - 1)) begin
      lvl_d = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign hpd_ok = lvl_q;

  AST_HPD_FALL_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hpd_ok) |-> (!s2_q && $past(!s2_q))); // R2
  AST_HPD_HIGH_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    s2_q |=> hpd_ok); // R1
endmodule

// File: rtl/sd_block_scan.sv
module sd_block_scan
  import sinkdisc_pkg::*;
#(
  parameter logic [23:0] VSDB_ID = 24'h000C03
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld,
  input  logic [6:0] byte_off,
  input  logic [7:0] byte_dat,
  input  logic       in_ext,
  output logic       sum_ok,
  output logic       vsdb_hit
);
  logic [7:0] sum_q, sum_d;
  logic [7:0] nxt_q, nxt_d;
  logic [7:0] end_q, end_d;
  logic [6:0] base_q, base_d;
  logic       live_q, live_d;
  logic       hit_q, hit_d;

  logic [7:0] off8;
  logic [6:0] idx;
  logic [1:0] kk;
  logic       at_hdr;
  logic [7:0] want;

  assign off8   = {1'b0, byte_off};
  assign idx    = byte_off - base_q;
  assign kk     = idx[1:0] - 2'd1;
  assign want   = VSDB_ID[{kk, 3'b000} +: 8];
  assign at_hdr = (off8 == nxt_q) && (off8 >= COLL_START) && (off8 < end_q);

  always_comb begin
    sum_d  = sum_q;
    nxt_d  = nxt_q;
    end_d  = end_q;
    base_d = base_q;
    live_d = live_q;
    hit_d  = hit_q;
    if (byte_vld) begin
      sum_d = (byte_off == 7'd0) ? byte_dat : sum_q + byte_dat;
      if (byte_off == 7'd0) begin
        nxt_d  = COLL_START;
        end_d  = 8'd0;
        base_d = 7'd0;
        live_d = 1'b0;
        hit_d  = 1'b0;
      end else if (in_ext) begin
        if (byte_off == 7'd2) begin
          end_d = byte_dat;
        end else if (at_hdr) begin
          nxt_d  = off8 + {3'b000, byte_dat[4:0]} + 8'd1;
          base_d = byte_off;
          live_d = (byte_dat[7:5] == DB_TAG_VENDOR) && (byte_dat[4:0] >= 5'd3);
        end else if (live_q && idx >= 7'd1 && idx <= 7'd3) begin
          if (byte_dat != want) live_d = 1'b0;
          else if (idx == 7'd3) hit_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= 8'd0;
      nxt_q  <= COLL_START;
      end_q  <= 8'd0;
      base_q <= 7'd0;
      live_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      sum_q  <= sum_d;
      nxt_q  <= nxt_d;
      end_q  <= end_d;
      base_q <= base_d;
      live_q <= live_d;
      hit_q  <= hit_d;
    end
  end

  assign sum_ok   = (sum_q == 8'd0);
  assign vsdb_hit = hit_q;

  AST_HIT_NEEDS_CANDIDATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_q) |-> $past(live_q)); // R8
  AST_HIT_ONLY_IN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_q) |-> $past(in_ext)); // R7
endmodule

// File: rtl/sd_fetch_seq.sv
module sd_fetch_seq
  import sinkdisc_pkg::*;
#(
  parameter int MAX_RETRY = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hpd_ok,
  output logic       rd_req,
  output logic [7:0] rd_addr,
  input  logic       rd_ack,
  input  logic [7:0] rd_data,
  output logic       byte_vld,
  output logic [6:0] byte_off,
  output logic       in_ext,
  input  logic       sum_ok,
  input  logic       vsdb_hit,
  output logic       caps_valid,
  output logic       caps_fail,
  output logic       sink_hdmi
);
  localparam int RW = $clog2(MAX_RETRY + 2);

  fetch_st_t     st_q, st_d;
  logic [7:0]    addr_q, addr_d;
  logic [RW-1:0] try_q, try_d;
  logic          extn_q, extn_d;
  logic          tag_q, tag_d;
  logic          hdmi_q, hdmi_d;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    try_d  = try_q;
    extn_d = extn_q;
    tag_d  = tag_q;
    hdmi_d = hdmi_q;
    unique case (st_q)
      ST_IDLE: begin
        hdmi_d = 1'b0;
        if (hpd_ok) begin
          addr_d = 8'd0;
          try_d  = '0;
          st_d   = ST_REQ;
        end
      end
      ST_REQ: begin
        if (!hpd_ok) begin
          st_d = ST_IDLE;
        end else if (rd_ack) begin
          if (!addr_q[7] && addr_q[6:0] == EXT_CNT_OFF) extn_d = (rd_data != 8'd0);
          if (addr_q == 8'd128) tag_d = (rd_data == EXT_TAG_CEA);
          if (addr_q[6:0] == LAST_OFF) st_d = ST_CHECK;
          else addr_d = addr_q + 8'd1;
        end
      end
      ST_CHECK: begin
        if (!hpd_ok) begin
          st_d = ST_IDLE;
        end else if (!sum_ok) begin
          if (try_q == RW'(MAX_RETRY)) begin
            st_d = ST_FAIL;
          end else begin
            try_d  = try_q + 1'b1;
            addr_d = {addr_q[7], 7'd0};
            st_d   = ST_REQ;
          end
        end else if (!addr_q[7]) begin
          if (!extn_q) begin
            hdmi_d = 1'b0;
            st_d   = ST_DONE;
          end else begin
            addr_d = 8'd128;
            try_d  = '0;
            st_d   = ST_REQ;
          end
        end else begin
          hdmi_d = tag_q & vsdb_hit;
          st_d   = ST_DONE;
        end
      end
      ST_DONE, ST_FAIL: begin
        if (!hpd_ok) begin
          hdmi_d = 1'b0;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= 8'd0;
      try_q  <= '0;
      extn_q <= 1'b0;
      tag_q  <= 1'b0;
      hdmi_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      try_q  <= try_d;
      extn_q <= extn_d;
      tag_q  <= tag_d;
      hdmi_q <= hdmi_d;
    end
  end

  assign rd_req     = (st_q == ST_REQ);
  assign rd_addr    = addr_q;
  assign byte_vld   = (st_q == ST_REQ) && rd_ack && hpd_ok;
  assign byte_off   = addr_q[6:0];
  assign in_ext     = addr_q[7];
  assign caps_valid = (st_q == ST_DONE);
  assign caps_fail  = (st_q == ST_FAIL);
  assign sink_hdmi  = hdmi_q;

  AST_NO_REQ_WITHOUT_HPD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !hpd_ok) |=> (st_q == ST_IDLE)); // R1
  AST_ABORT_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hpd_ok) |=> (st_q == ST_IDLE)); // R9
  AST_BAD_SUM_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CHECK && !sum_ok) |=> (st_q != ST_DONE)); // R6
  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    try_q <= RW'(MAX_RETRY)); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ack && hpd_ok && addr_q[6:0] != LAST_OFF) |=> (rd_addr == $past(rd_addr) + 8'd1)); // R4
  AST_HDMI_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    sink_hdmi |-> caps_valid); // R7
endmodule

// File: rtl/sink_discovery_ctrl.sv
module sink_discovery_ctrl #(
  parameter int          HPD_LOW_MIN = 4096,
  parameter int          MAX_RETRY   = 2,
  parameter logic [23:0] VSDB_ID     = 24'h000C03
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hpd_in,
  output logic       ddc_rd_req,
  output logic [7:0] ddc_rd_addr,
  input  logic       ddc_rd_ack,
  input  logic [7:0] ddc_rd_data,
  output logic       pwr5v_en,
  output logic       caps_valid,
  output logic       caps_fail,
  output logic       sink_hdmi,
  output logic       safe_mode
);
  logic       rst_meta_q, rst_sync_q;
  logic       pwr_q;
  logic       hpd_ok;
  logic       byte_vld;
  logic [6:0] byte_off;
  logic       in_ext;
  logic       sum_ok;
  logic       vsdb_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) pwr_q <= 1'b0;
    else             pwr_q <= 1'b1;
  end

  sd_hpd_filter #(.LOW_MIN(HPD_LOW_MIN)) u_hpd (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .hpd_raw (hpd_in),
    .hpd_ok  (hpd_ok)
  );

  sd_fetch_seq #(.MAX_RETRY(MAX_RETRY)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .hpd_ok     (hpd_ok),
    .rd_req     (ddc_rd_req),
    .rd_addr    (ddc_rd_addr),
    .rd_ack     (ddc_rd_ack),
    .rd_data    (ddc_rd_data),
    .byte_vld   (byte_vld),
    .byte_off   (byte_off),
    .in_ext     (in_ext),
    .sum_ok     (sum_ok),
    .vsdb_hit   (vsdb_hit),
    .caps_valid (caps_valid),
    .caps_fail  (caps_fail),
    .sink_hdmi  (sink_hdmi)
  );

  sd_block_scan #(.VSDB_ID(VSDB_ID)) u_scan (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .byte_vld (byte_vld),
    .byte_off (byte_off),
    .byte_dat (ddc_rd_data),
    .in_ext   (in_ext),
    .sum_ok   (sum_ok),
    .vsdb_hit (vsdb_hit)
  );

  assign pwr5v_en  = pwr_q;
  assign safe_mode = !caps_valid;

  AST_PWR_DURING_DDC: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ddc_rd_req |-> pwr5v_en); // R3
  AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !(caps_valid && caps_fail)); // R10
endmodule

// File: tb/sink_discovery_ctrl_tb.sv
module sink_discovery_ctrl_tb;
  localparam int LOW_MIN = 16;
  localparam int RETRY   = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       hpd_in;
  logic       ddc_rd_req;
  logic [7:0] ddc_rd_addr;
  logic       ddc_rd_ack;
  logic [7:0] ddc_rd_data;
  logic       pwr5v_en, caps_valid, caps_fail, sink_hdmi, safe_mode;

  always #5 clk = ~clk;

  sink_discovery_ctrl #(.HPD_LOW_MIN(LOW_MIN), .MAX_RETRY(RETRY)) u_dut (
    .clk(clk), .rst_n(rst_n), .hpd_in(hpd_in),
    .ddc_rd_req(ddc_rd_req), .ddc_rd_addr(ddc_rd_addr),
    .ddc_rd_ack(ddc_rd_ack), .ddc_rd_data(ddc_rd_data),
    .pwr5v_en(pwr5v_en), .caps_valid(caps_valid), .caps_fail(caps_fail),
    .sink_hdmi(sink_hdmi), .safe_mode(safe_mode)
  );

  typedef struct packed { logic hdmi; logic fail; } exp_t;
  exp_t q[$];

  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 0;
  logic [7:0] img [256];
  int   reads_total = 0;
  int   ext_reads = 0;
  int   blk0_starts = 0;
  int   corrupt_left = 0;
  int   first_addr = -1;
  bit   watch_first = 0;
  int   exp_next = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Image builder: returns expected HDMI classification from the rules.
  function automatic bit build(input int ext_cnt, input int ext_tag, input int vs_tag, input int coll_end);
    int s;
    s = 0;
    for (int i = 0; i < 126; i++) img[i] = 8'(i * 7 + 1);
    img[126] = 8'(ext_cnt);
    for (int i = 0; i < 127; i++) s += img[i];
    img[127] = 8'(256 - (s % 256));
    for (int i = 128; i < 256; i++) img[i] = 8'h00;
    img[128] = 8'(ext_tag);
    img[129] = 8'h03;
    img[130] = 8'(coll_end);
    img[132] = {3'd2, 5'd3};
    img[133] = 8'h01; img[134] = 8'h02; img[135] = 8'h03;
    img[136] = {3'(vs_tag), 5'd5};
    img[137] = 8'h03; img[138] = 8'h0C; img[139] = 8'h00;
    img[140] = 8'h10;
    s = 0;
    for (int i = 128; i < 255; i++) s += img[i];
    img[255] = 8'(256 - (s % 256));
    return (ext_cnt != 0) && (ext_tag == 2) && (vs_tag == 3) && (coll_end > 8);
  endfunction

  // Sink model: answers each request after a short latency; checks order (R4).
  initial begin
    int lat;
    lat = 0;
    ddc_rd_ack = 1'b0;
    ddc_rd_data = 8'h00;
    forever begin
      @(negedge clk);
      ddc_rd_ack = 1'b0;
      if (ddc_rd_req) begin
        lat++;
        if (lat == 3) begin
          lat = 0;
          ddc_rd_ack = 1'b1;
          ddc_rd_data = img[ddc_rd_addr];
          if (ddc_rd_addr == 8'd5 && corrupt_left > 0) begin
            ddc_rd_data = ddc_rd_data ^ 8'h01;
            corrupt_left--;
          end
          if (ddc_rd_addr != 8'(exp_next) && ddc_rd_addr != 8'd0 && ddc_rd_addr != 8'd128)
            chk(0, "R4 address order", int'(ddc_rd_addr), exp_next);
          exp_next = int'(ddc_rd_addr) + 1;
          reads_total++;
          if (ddc_rd_addr >= 8'd128) ext_reads++;
          if (ddc_rd_addr == 8'd0) blk0_starts++;
          if (watch_first) begin
            first_addr = int'(ddc_rd_addr);
            watch_first = 0;
          end
        end
      end else begin
        lat = 0;
      end
    end
  end

  // Monitor: pops the expected outcome at each completed fetch.
  initial begin
    logic pv, pf;
    exp_t e;
    pv = 0; pf = 0;
    forever begin
      @(negedge clk);
      if (rst_n && ((caps_valid && !pv) || (caps_fail && !pf))) begin
        if (q.size() == 0) begin
          chk(0, "R10 unexpected result", 1, 0);
        end else begin
          e = q.pop_front();
          chk(caps_fail == e.fail, "R6 fail flag", int'(caps_fail), int'(e.fail));
          chk(sink_hdmi == e.hdmi, "R7 sink class", int'(sink_hdmi), int'(e.hdmi));
          chk(safe_mode == !caps_valid, "R10 safe mode", int'(safe_mode), int'(!caps_valid));
        end
      end
      pv = caps_valid;
      pf = caps_fail;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  task automatic push_exp(input bit hdmi, input bit fail);
    exp_t e;
    e.hdmi = hdmi;
    e.fail = fail;
    q.push_back(e);
  endtask

  task automatic wait_done(input string req);
    bit ok;
    ok = 0;
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk);
      if (q.size() == 0) begin ok = 1; break; end
    end
    chk(ok, req, int'(q.size()), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic long_low();
    hpd_in = 1'b0;
    repeat (LOW_MIN + 10) @(negedge clk);
    chk(!caps_valid && !caps_fail, "R2 caps cleared on long low", int'(caps_valid), 0);
    chk(safe_mode == 1'b1, "R2 safe mode on long low", int'(safe_mode), 1);
  endtask

  initial begin
    bit exp_h;
    int snap, b0;
    rst_n = 1'b0;
    hpd_in = 1'b0;
    exp_h = build(1, 2, 3, 14);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    // Reset state and no request while HPD low
    chk(ddc_rd_req == 1'b0, "R1 no request with hpd low", int'(ddc_rd_req), 0);
    chk(reads_total == 0, "R1 no reads with hpd low", reads_total, 0);
    chk(pwr5v_en == 1'b1, "R3 power enabled after reset", int'(pwr5v_en), 1);
    chk(safe_mode == 1'b1 && caps_valid == 1'b0, "R10 reset safe mode", int'(safe_mode), 1);

    // HDMI sink
    push_exp(exp_h, 1'b0);
    hpd_in = 1'b1;
    wait_done("R7 hdmi fetch completes");
    chk(ext_reads == 128, "R4 extension read once", ext_reads, 128);

    // Short glitch ignored
    snap = reads_total;
    hpd_in = 1'b0;
    repeat (LOW_MIN - 6) @(negedge clk);
    hpd_in = 1'b1;
    repeat (40) @(negedge clk);
    chk(caps_valid == 1'b1 && sink_hdmi == 1'b1, "R2 glitch keeps result", int'(caps_valid), 1);
    chk(reads_total == snap, "R2 glitch issues no reads", reads_total, snap);

    // Change pulse, new sink with wrong tag on the vendor entry -> DVI
    long_low();
    exp_h = build(1, 2, 1, 14);
    push_exp(exp_h, 1'b0);
    hpd_in = 1'b1;
    wait_done("R8 wrong tag fetch completes");

    // Extension count zero -> DVI, no extension reads
    long_low();
    exp_h = build(0, 2, 3, 14);
    snap = ext_reads;
    push_exp(exp_h, 1'b0);
    hpd_in = 1'b1;
    wait_done("R5 base only fetch completes");
    chk(ext_reads == snap, "R5 no extension reads", ext_reads - snap, 0);

    // Vendor entry beyond collection end -> DVI
    long_low();
    exp_h = build(1, 2, 3, 8);
    push_exp(exp_h, 1'b0);
    hpd_in = 1'b1;
    wait_done("R8 entry past end fetch completes");

    // Extension tag not 0x02 -> DVI
    long_low();
    exp_h = build(1, 7, 3, 14);
    push_exp(exp_h, 1'b0);
    hpd_in = 1'b1;
    wait_done("R7 wrong extension tag fetch completes");

    // Persistent checksum error -> fail after 1+RETRY base attempts
    long_low();
    exp_h = build(1, 2, 3, 14);
    b0 = blk0_starts;
    corrupt_left = 1000;
    push_exp(1'b0, 1'b1);
    hpd_in = 1'b1;
    wait_done("R6 failing fetch completes");
    chk(blk0_starts - b0 == RETRY + 1, "R6 base attempts", blk0_starts - b0, RETRY + 1);
    chk(safe_mode == 1'b1, "R6 safe mode after fail", int'(safe_mode), 1);
    corrupt_left = 0;

    // Transient checksum error -> one retry then HDMI
    long_low();
    b0 = blk0_starts;
    corrupt_left = 1;
    push_exp(exp_h, 1'b0);
    hpd_in = 1'b1;
    wait_done("R6 transient error fetch completes");
    chk(blk0_starts - b0 == 2, "R6 single retry", blk0_starts - b0, 2);

    // Abort during read, then restart from address 0
    long_low();
    snap = reads_total;
    hpd_in = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (reads_total >= snap + 50) break;
    end
    hpd_in = 1'b0;
    repeat (LOW_MIN + 6) @(negedge clk);
    chk(ddc_rd_req == 1'b0, "R9 request withdrawn on drop", int'(ddc_rd_req), 0);
    snap = reads_total;
    repeat (20) @(negedge clk);
    chk(reads_total == snap && !caps_valid, "R9 no reads after abort", reads_total, snap);
    watch_first = 1;
    push_exp(exp_h, 1'b0);
    hpd_in = 1'b1;
    wait_done("R9 fetch after abort completes");
    chk(first_addr == 0, "R9 restart at address 0", first_addr, 0);
    chk(pwr5v_en == 1'b1, "R3 power still enabled", int'(pwr5v_en), 1);

    summary();
  end
endmodule